// File: doc/BRIEF.md
# Tributary slot insertion selector

This block fills 28 outgoing virtual-tributary slots from 28 tributary input streams. Each slot has its own control register. A 5-bit source code in that register chooses what the slot carries: one of the tributary inputs, a constant unequipped fill, a constant AIS fill, or a shared pseudo-random test pattern. The same register has a loopback enable. When it is set, tributary input n is replaced by the bit that slot n sent on the previous strobe.

All tributaries share one bit strobe. On each strobe every slot registers one new output bit. Upstream detectors supply per-input AIS and loss-of-clock flags, and a read of a slot register returns them live. Software programs the slots through a simple byte-wide read/write bus. Framing, pointer handling and the alarm detectors themselves are outside this block.

Top module: `tsi_insert_sel`

## Requirements
- R1: Register n (n = 1..28) is at bus address 0x16+n and controls slot n. A write stores wdata[4:0] as its source code and wdata[5] as its loopback enable. A later read returns these two fields in bits 4:0 and bit 5.
- R2: After reset every source code is 0, every loopback enable is 0, all slot outputs are 0 and the read data is 0. The slots therefore send unequipped fill until they are reprogrammed.
- R3: With a code from 1 to 28, slot n outputs the value of tributary input k (k = the code) as it was at the strobe edge. Input k is bit k-1 of trib_data, and slot n is bit n-1 of slot_data.
- R4: Code 0 makes the slot output a constant 0 (unequipped fill) at every strobe.
- R5: Codes 29 and 30 make the slot output a constant 1 (AIS fill) at every strobe.
- R6: Code 31 makes the slot output the test pattern. One 15-stage generator with feedback x^15+x^14+1 (new bit = stage15 XOR stage14) drives all such slots. It is seeded to all ones at reset, advances only on strobes, and the slot takes stage 15 before the shift.
- R7: Read bit 7 is the live AIS flag of tributary input n, and read bit 6 is its live loss-of-clock flag, both sampled at the read edge and never latched. Writes to bits 7 and 6 have no effect.
- R8: When the loopback enable of register n is 1, every slot that selects input n receives slot n's output from the previous strobe in place of trib_data[n-1].
- R9: A new code applies from the first strobe after the write edge. A strobe on the same edge as the write still uses the old code.
- R10: A read of any address outside 0x17..0x32 returns 0. A write to such an address changes no register.
- R11: slot_data changes only on clock edges where bit_stb is 1.
- R12: Read data appears on bus_rdata after the edge that samples bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_stb | input | 1 | Shared tributary bit strobe |
| trib_data | input | 28 | One data bit per tributary input, input n on bit n-1 |
| trib_ais | input | 28 | Live AIS flag per tributary input |
| trib_loc | input | 28 | Live loss-of-clock flag per tributary input |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| slot_data | output | 28 | One outgoing bit per slot, slot n on bit n-1 |

## Verification
A slot bit is due on the clock edge that samples bit_stb, through a single register. That edge uses the inputs, the codes and the generator state present just before it. Read data is due one edge after bus_rd, and a new code first shows at the strobe after its write edge. The bench predicts each result from the stimulus it has driven before that edge, updates its model at the edge, and compares one time unit later. It drives all inputs on the falling edge, so every comparison falls between edges.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NUM_TRIB   = 28;
  localparam int SEL_W      = 5;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int REG_BASE   = 8'h17;
  localparam int CODE_UNEQ  = 0;
  localparam int CODE_AIS_A = 29;
  localparam int CODE_AIS_B = 30;
  localparam int CODE_TEST  = 31;
  localparam int PRBS_LEN   = 15;
  localparam int PRBS_TAP   = 14;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/tsi_rst_sync.sv
module tsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/tsi_prbs.sv
module tsi_prbs #(
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_o
);
  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_d;
  logic           fb;

  always_comb begin
    fb      = state_q[LEN-1] ^ state_q[TAP-1];
    state_d = {state_q[LEN-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= '1;
    else if (adv) state_q <= state_d;
  end

  assign bit_o = state_q[LEN-1];

  AST_PRBS_NOT_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R6
  AST_PRBS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q)); // R6
endmodule

// File: rtl/tsi_regfile.sv
module tsi_regfile #(
  parameter int NUM    = 28,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BASE   = 8'h17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic [NUM-1:0]              ais,
  input  logic [NUM-1:0]              loc,
  output logic [NUM-1:0][SEL_W-1:0]   sel_o,
  output logic [NUM-1:0]              lb_o,
  output logic [DATA_W-1:0]           bus_rdata
);
  localparam int IDX_W   = $clog2(NUM);
  localparam int LB_BIT  = SEL_W;
  localparam int LOC_BIT = SEL_W + 1;
  localparam int AIS_BIT = SEL_W + 2;

  logic [ADDR_W-1:0]         off;
  logic                      in_win;
  logic [IDX_W-1:0]          idx;
  logic [NUM-1:0]            wr_hit;
  logic [NUM-1:0][SEL_W-1:0] sel_q;
  logic [NUM-1:0]            lb_q;
  logic [DATA_W-1:0]         rdata_d;
  logic [DATA_W-1:0]         rdata_q;

  // address decode
  always_comb begin
    off    = bus_addr - ADDR_W'(BASE);
    in_win = (bus_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(NUM));
    idx    = off[IDX_W-1:0];
  end

  // per-register storage; status bits are never stored
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    assign wr_hit[i] = bus_wr && in_win && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
        lb_q[i]  <= 1'b0;
      end else if (wr_hit[i]) begin
        sel_q[i] <= bus_wdata[SEL_W-1:0];
        lb_q[i]  <= bus_wdata[LB_BIT];
      end
    end
  end

  // read mux with live status
  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM; i++) begin
      if (in_win && (idx == IDX_W'(i))) begin
        rdata_d[SEL_W-1:0] = sel_q[i];
        rdata_d[LB_BIT]    = lb_q[i];
        rdata_d[LOC_BIT]   = loc[i];
        rdata_d[AIS_BIT]   = ais[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign sel_o     = sel_q;
  assign lb_o      = lb_q;
  assign bus_rdata = rdata_q;

  AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !in_win |=> bus_rdata == '0); // R10
  AST_WR_OUTSIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !in_win |=> $stable(sel_q) && $stable(lb_q)); // R10
  AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R12
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(sel_q) && $stable(lb_q)); // R1
endmodule

// File: rtl/tsi_slot_sel.sv
module tsi_slot_sel #(
  parameter int NUM   = 28,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic [SEL_W-1:0] sel,
  input  logic [NUM-1:0]   trib_vec,
  input  logic             prbs_bit,
  output logic             slot_q
);
  import tsi_pkg::*;

  logic pick;

  always_comb begin
    pick = 1'b0;
    if (sel == SEL_W'(CODE_TEST)) begin
      pick = prbs_bit;
    end else if ((sel == SEL_W'(CODE_AIS_A)) || (sel == SEL_W'(CODE_AIS_B))) begin
      pick = 1'b1;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (sel == SEL_W'(i + 1)) pick = trib_vec[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= 1'b0;
    else if (bit_stb) slot_q <= pick;
  end

  AST_UNEQ_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && (sel == SEL_W'(CODE_UNEQ)) |=> !slot_q); // R4
  AST_AIS_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && ((sel == SEL_W'(CODE_AIS_A)) || (sel == SEL_W'(CODE_AIS_B))) |=> slot_q); // R5
  AST_TEST_FOLLOWS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && (sel == SEL_W'(CODE_TEST)) |=> slot_q == $past(prbs_bit)); // R6
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(slot_q)); // R11
endmodule

// File: rtl/tsi_insert_sel.sv
module tsi_insert_sel
  import tsi_pkg::*;
#(
  parameter int NUM  = NUM_TRIB,
  parameter int SW   = SEL_W,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int BASE = REG_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic [NUM-1:0] trib_data,
  input  logic [NUM-1:0] trib_ais,
  input  logic [NUM-1:0] trib_loc,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NUM-1:0] slot_data
);
  logic                   rst_sn;
  logic [NUM-1:0][SW-1:0] sel;
  logic [NUM-1:0]         lb;
  logic [NUM-1:0]         eff_in;
  logic [NUM-1:0]         slot_q;
  logic                   prbs_bit;

  tsi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  tsi_regfile #(
    .NUM(NUM), .SEL_W(SW), .ADDR_W(AW), .DATA_W(DW), .BASE(BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .ais       (trib_ais),
    .loc       (trib_loc),
    .sel_o     (sel),
    .lb_o      (lb),
    .bus_rdata (bus_rdata)
  );

  tsi_prbs #(.LEN(PRBS_LEN), .TAP(PRBS_TAP)) u_prbs (
    .clk   (clk),
    .rst_n (rst_sn),
    .adv   (bit_stb),
    .bit_o (prbs_bit)
  );

  // loopback: previous strobe's slot bit replaces the input at the same position
  always_comb begin
    eff_in = (trib_data & ~lb) | (slot_q & lb);
  end

  for (genvar n = 0; n < NUM; n++) begin : g_slot
    tsi_slot_sel #(.NUM(NUM), .SEL_W(SW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sn),
      .bit_stb  (bit_stb),
      .sel      (sel[n]),
      .trib_vec (eff_in),
      .prbs_bit (prbs_bit),
      .slot_q   (slot_q[n])
    );

    AST_SELF_LOOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_sn)
      bit_stb && lb[n] && (sel[n] == SW'(n + 1)) |=> $stable(slot_q[n])); // R8
  end

  assign slot_data = slot_q;
endmodule

// File: tb/tsi_insert_sel_bench.sv
module tsi_insert_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_stb;
  logic [NT-1:0] trib_data, trib_ais, trib_loc;
  logic [7:0]    bus_addr, bus_wdata, bus_rdata;
  logic          bus_wr, bus_rd;
  logic [NT-1:0] slot_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_insert_sel u_tsi_insert_sel (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .trib_data(trib_data), .trib_ais(trib_ais), .trib_loc(trib_loc),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_data(slot_data)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_tag = "R2";

  logic [4:0]    exp_sel [NT];
  logic [NT-1:0] exp_lb;
  logic [NT-1:0] exp_slot;
  logic [14:0]   exp_prbs;
  logic [7:0]    exp_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic pick(input logic [4:0] code, input logic [NT-1:0] v, input logic pb);
    if (code == 5'd31) return pb;
    if (code == 5'd29 || code == 5'd30) return 1'b1;
    if (code >= 5'd1 && code <= 5'd28) return v[code - 5'd1];
    return 1'b0;
  endfunction

  function automatic logic in_win(input logic [7:0] a);
    return (a >= 8'h17) && (a <= 8'h32);
  endfunction

  task automatic step(input logic stb, input logic wr, input logic rd,
                      input logic [7:0] addr, input logic [7:0] wd);
    logic [NT-1:0] eff;
    logic [NT-1:0] nxt;
    int            k;
    bit_stb = stb; bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
    eff = (trib_data & ~exp_lb) | (exp_slot & exp_lb);
    nxt = exp_slot;
    if (stb) for (int n = 0; n < NT; n++) nxt[n] = pick(exp_sel[n], eff, exp_prbs[14]);
    if (rd) begin
      if (in_win(addr)) begin
        k = int'(addr - 8'h17);
        exp_rd = {trib_ais[k], trib_loc[k], exp_lb[k], exp_sel[k]};
      end else exp_rd = 8'h00;
    end
    @(posedge clk); #1;
    exp_slot = nxt;
    if (stb) exp_prbs = {exp_prbs[13:0], exp_prbs[14] ^ exp_prbs[13]};
    if (wr && in_win(addr)) begin
      k = int'(addr - 8'h17);
      exp_sel[k] = wd[4:0];
      exp_lb[k]  = wd[5];
    end
    chk({cur_tag, " slot_data"}, 32'(slot_data), 32'(exp_slot));
    chk({cur_tag, " bus_rdata"}, 32'(bus_rdata), 32'(exp_rd));
    @(negedge clk);
  endtask

  task automatic wr_reg(input int n, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b0, 8'(8'h16 + n), d);
  endtask

  task automatic rd_reg(input int n);
    step(1'b0, 1'b0, 1'b1, 8'(8'h16 + n), 8'h00);
  endtask

  task automatic strobes(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      trib_data = NT'($urandom);
      step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bit_stb = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    trib_data = '0; trib_ais = '0; trib_loc = '0;
    for (int n = 0; n < NT; n++) exp_sel[n] = 5'd0;
    exp_lb = '0; exp_slot = '0; exp_prbs = '1; exp_rd = 8'h00;
    repeat (5) @(negedge clk);
    // R2: reset state
    chk("R2 slot_data", 32'(slot_data), 32'h0);
    chk("R2 bus_rdata", 32'(bus_rdata), 32'h0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    cur_tag = "R2";
    rd_reg(1); rd_reg(28);
    strobes(4);

    // R1: writes with bits 7:6 set are stored only in 5:0
    cur_tag = "R1";
    for (int n = 1; n <= NT; n++) wr_reg(n, {2'b11, 1'(n % 2), 5'(n)});
    for (int n = 1; n <= NT; n++) rd_reg(n);

    // R7: live status bits, not latched
    cur_tag = "R7";
    for (int n = 1; n <= NT; n++) begin
      trib_ais = NT'($urandom); trib_loc = NT'($urandom);
      rd_reg(n);
    end
    trib_ais = '0; trib_loc = '0;
    rd_reg(5);

    // R3: tributary selection
    cur_tag = "R3";
    for (int n = 1; n <= NT; n++) wr_reg(n, {3'b000, 5'(((n * 5) % NT) + 1)});
    strobes(40);

    // R4: unequipped
    cur_tag = "R4";
    for (int n = 1; n <= NT; n++) wr_reg(n, 8'h00);
    strobes(20);

    // R5: AIS fill with both codes
    cur_tag = "R5";
    for (int n = 1; n <= NT; n++) wr_reg(n, (n % 2) ? 8'd29 : 8'd30);
    strobes(10);

    // R6: test pattern with strobe gaps
    cur_tag = "R6";
    for (int n = 1; n <= NT; n++) wr_reg(n, 8'd31);
    for (int i = 0; i < 80; i++) begin
      trib_data = NT'($urandom);
      step(1'($urandom), 1'b0, 1'b0, 8'h00, 8'h00);
    end

    // R11: no strobe, inputs move, output holds
    cur_tag = "R11";
    for (int n = 1; n <= NT; n++) wr_reg(n, 8'(n));
    for (int i = 0; i < 12; i++) begin
      trib_data = NT'($urandom);
      step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    end

    // R8: loopback chain and self loop
    cur_tag = "R8";
    wr_reg(1, 8'h3F);          // loopback, test pattern
    wr_reg(2, 8'h01);          // takes looped input 1
    wr_reg(3, 8'h23);          // loopback, selects itself: freezes
    strobes(30);

    // R9: write on the same edge as a strobe
    cur_tag = "R9";
    trib_data = '1;
    wr_reg(4, 8'h04);
    strobes(2);
    trib_data = '1;
    step(1'b1, 1'b1, 1'b0, 8'h1A, 8'h00); // old code (4) still used
    strobes(3);                          // new code 0 from here

    // R10: outside window
    cur_tag = "R10";
    step(1'b0, 1'b1, 1'b0, 8'h16, 8'h1F);
    step(1'b0, 1'b1, 1'b0, 8'h33, 8'h1F);
    step(1'b0, 1'b1, 1'b0, 8'hFF, 8'h1F);
    trib_ais = '1; trib_loc = '1;
    step(1'b0, 1'b0, 1'b1, 8'h16, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h33, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    rd_reg(1); rd_reg(28);

    // R12: read data holds while status changes
    cur_tag = "R12";
    rd_reg(7);
    for (int i = 0; i < 6; i++) begin
      trib_ais = NT'($urandom); trib_loc = NT'($urandom);
      step(1'b0, 1'b0, 1'b0, 8'h17, 8'h00);
    end
    trib_ais = '0; trib_loc = '0;

    // random mix over all requirements
    cur_tag = "R3/R6/R8 random";
    for (int i = 0; i < 3000; i++) begin
      trib_data = NT'($urandom);
      trib_ais  = NT'($urandom);
      trib_loc  = NT'($urandom);
      step(1'(($urandom % 2) == 0), 1'(($urandom % 8) == 0), 1'(($urandom % 5) == 0),
           8'(8'h14 + ($urandom % 34)), 8'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule